// File: doc/BRIEF.md
# 64-bit Compare-Match Timer

This peripheral keeps a 64-bit up-counter that advances once per clock while counting is enabled. A 64-bit compare value is checked against it on every cycle. When comparison is enabled and the count has reached or passed the compare value, a sticky event flag is raised. That flag drives a level interrupt when the interrupt enable bit is also set. In periodic mode, each event adds a 32-bit step to the compare value, so events recur once every step counts and no software re-arm is needed.

Software reaches the block through a single-cycle 32-bit register port. Read data is a combinational view of the selected register. Writes take effect at the clock edge on which the write enable is sampled. The counter and the compare value are each split into a low and a high word.

A carry from the low word into the high word lands on the same edge as the low word wraps. Software can therefore take a coherent snapshot by reading the high word, then the low word, then the high word again. It accepts the pair when the two high reads agree. To reprogram the compare value without a stray event, software turns off comparison, writes both words, and then turns comparison back on.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. A read of word index 7 (byte offset 0x1C) returns zero, and a write to that offset changes no register.
- R2: While control bit 0 is 1, the counter increases by exactly one per clock and wraps from all ones to zero. While control bit 0 is 0, the counter holds its value.
- R3: Byte offset 0x00 reads counter bits 31:0 and offset 0x04 reads bits 63:32. A carry out of the low word reaches the high word on the same clock edge as the low word wraps.
- R4: A write to offset 0x00 or 0x04 loads that counter word. That write replaces the increment for that cycle, and the written value reads back on the next cycle.
- R5: An event occurs in a cycle when control bit 1 is 1 and the counter is greater than or equal to the compare value. It is not limited to equality. The event sets status bit 0 (offset 0x0C) on the following clock edge.
- R6: While control bit 1 is 0, status bit 0 is never set, whatever the counter and compare values are.
- R7: Writing a 1 to bit 0 of offset 0x0C clears the flag. If an event occurs in the same cycle, the flag stays set.
- R8: `irq` equals status bit 0 AND control bit 2, as a level. It falls as soon as the flag is cleared or the interrupt enable is cleared.
- R9: When control bit 3 is 1, each event adds the step register (offset 0x18, 32 bits, zero-extended) to the 64-bit compare value (offsets 0x10 low word and 0x14 high word) on the same edge that sets the flag. A compare write in the same cycle takes priority over the add.
- R10: The control register at offset 0x08 holds four bits, which read back as written, with all upper bits reading zero: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 periodic mode. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The counter is loaded close to a word boundary and at all ones. Reading the two words back cycle by cycle then separates a same-edge carry from a late one, and shows whether a wrap is correct. The compare path is tested with exactly twenty counts to go, which fixes the first set cycle to the exact edge. It is then tested with the counter already past the compare value, which tells a greater-or-equal comparator apart from an equality comparator. Further patterns cover a disabled comparator held over a matching count, a clear that collides with a live event, and periodic mode observed across two successive reloads, which confirms that the step is added only on event cycles.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int MT_ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_CNT_LO  = 3'd0,
        SEL_CNT_HI  = 3'd1,
        SEL_CTRL    = 3'd2,
        SEL_STAT    = 3'd3,
        SEL_CMP_LO  = 3'd4,
        SEL_CMP_HI  = 3'd5,
        SEL_STEP    = 3'd6,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic periodic;  // bit 3
        logic irq_en;    // bit 2
        logic cmp_en;    // bit 1
        logic run;       // bit 0
    } ctrl_t;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [WORD_W-1:0]     wdata,
    output logic [2*WORD_W-1:0]   count
);
    localparam int CW = 2 * WORD_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[WORD_W-1:0]  = wdata;
            if (wr_hi) st_d.cnt[CW-1:WORD_W] = wdata;
        end else if (run) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R2: one step per clock while running, wrapping modulo 2^CW
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_lo && !wr_hi) |=> (count == $past(count) + CW'(1)));

    // R2: count holds while stopped
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));

    // R4: a low-word write lands regardless of the run bit
    p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[WORD_W-1:0] == $past(wdata)));
endmodule

// File: rtl/mt_comparator.sv
module mt_comparator #(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*WORD_W-1:0]   count,
    input  logic                  cmp_en,
    input  logic                  periodic,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_step,
    input  logic                  clr_req,
    input  logic [WORD_W-1:0]     wdata,
    output logic [2*WORD_W-1:0]   compare,
    output logic [WORD_W-1:0]     step,
    output logic                  flag
);
    localparam int CW = 2 * WORD_W;

    typedef struct packed {
        logic [CW-1:0]     cmp;
        logic [WORD_W-1:0] step;
        logic              flag;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = cmp_en && (count >= st_q.cmp);
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cmp[WORD_W-1:0]  = wdata;
            if (wr_hi) st_d.cmp[CW-1:WORD_W] = wdata;
        end else if (hit && periodic) begin
            st_d.cmp = st_q.cmp + CW'(st_q.step);
        end
        if (wr_step) st_d.step = wdata;
        if (hit)          st_d.flag = 1'b1;
        else if (clr_req) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign compare = st_q.cmp;
    assign step    = st_q.step;
    assign flag    = st_q.flag;

    // R6: the flag can only rise after a cycle with comparison enabled
    p_flag_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cmp_en));

    // R5: reaching or passing the compare value sets the flag next cycle
    p_ge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (count >= compare)) |=> flag);

    // R7: a clear with no event drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(cmp_en && (count >= compare))) |=> !flag);

    // R9: periodic reload adds the step on an event
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && periodic && (count >= compare) && !wr_lo && !wr_hi)
        |=> (compare == $past(compare) + CW'($past(step))));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [mt_pkg::MT_ADDR_W-1:0] bus_addr,
    input  logic                         bus_we,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    output logic                         irq
);
    import mt_pkg::*;
    localparam int CW = 2 * WORD_W;

    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t        st_d, st_q;
    reg_sel_e          sel;
    logic [CW-1:0]     count;
    logic [CW-1:0]     compare;
    logic [WORD_W-1:0] step;
    logic              flag;
    logic              unused_addr_lsb;

    assign sel             = reg_sel_e'(bus_addr[MT_ADDR_W-1:2]);
    assign unused_addr_lsb = ^bus_addr[1:0];

    always_comb begin
        st_d = st_q;
        if (bus_we && sel == SEL_CTRL) st_d.ctrl = ctrl_t'(bus_wdata[3:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mt_counter #(.WORD_W(WORD_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.ctrl.run),
        .wr_lo (bus_we && sel == SEL_CNT_LO),
        .wr_hi (bus_we && sel == SEL_CNT_HI),
        .wdata (bus_wdata),
        .count (count)
    );

    mt_comparator #(.WORD_W(WORD_W)) u_comparator (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .cmp_en   (st_q.ctrl.cmp_en),
        .periodic (st_q.ctrl.periodic),
        .wr_lo    (bus_we && sel == SEL_CMP_LO),
        .wr_hi    (bus_we && sel == SEL_CMP_HI),
        .wr_step  (bus_we && sel == SEL_STEP),
        .clr_req  (bus_we && sel == SEL_STAT && bus_wdata[0]),
        .wdata    (bus_wdata),
        .compare  (compare),
        .step     (step),
        .flag     (flag)
    );

    always_comb begin
        case (sel)
            SEL_CNT_LO: bus_rdata = count[WORD_W-1:0];
            SEL_CNT_HI: bus_rdata = count[CW-1:WORD_W];
            SEL_CTRL:   bus_rdata = WORD_W'(st_q.ctrl);
            SEL_STAT:   bus_rdata = WORD_W'(flag);
            SEL_CMP_LO: bus_rdata = compare[WORD_W-1:0];
            SEL_CMP_HI: bus_rdata = compare[CW-1:WORD_W];
            SEL_STEP:   bus_rdata = step;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = flag && st_q.ctrl.irq_en;

    // R8: a falling flag takes the interrupt down with it
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> !irq);

    // R10: control readback matches the last control write
    p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_CTRL) |=> (st_q.ctrl == $past(bus_wdata[3:0])));
endmodule

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0;
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    // monitor: compares each queued item in the cycle it was issued
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                tests_run++;
                if (act !== it.exp) begin
                    tests_failed++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every offset, including unmapped
        for (int i = 0; i < 8; i++) rd(5'(i * 4), 32'h0, "R1 reset value");
        rd_irq(1'b0, "R1 irq after reset");

        // R3: carry from low word lands on the same edge
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'h0000_0005);
        wr(5'h08, 32'h1);
        rd(5'h00, 32'hFFFF_FFFE, "R3 low before carry");
        rd(5'h04, 32'h5, "R3 high before carry");
        rd(5'h00, 32'h0, "R3 low wrapped");
        rd(5'h04, 32'h6, "R3 high carried");
        wr(5'h08, 32'h0);
        rd(5'h00, 32'h3, "R2 stopped value");
        rd(5'h00, 32'h3, "R2 hold while stopped");

        // R2: full 64-bit wrap
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'h1);
        rd(5'h04, 32'hFFFF_FFFF, "R2 high at all ones");
        rd(5'h04, 32'h0, "R2 high after wrap");
        rd(5'h00, 32'h1, "R2 low after wrap");
        // R4: write while running replaces the increment
        wr(5'h00, 32'h100);
        rd(5'h00, 32'h100, "R4 written value");
        rd(5'h00, 32'h101, "R4 counting resumes");
        wr(5'h08, 32'h0);

        // R6: comparator disabled, count >= compare (both zero-ish)
        wr(5'h08, 32'h5);
        idle(3);
        rd(5'h0C, 32'h0, "R6 no flag while disabled");
        rd_irq(1'b0, "R6 no irq while disabled");

        // R5: exact first set cycle, twenty counts ahead
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'd20);
        wr(5'h08, 32'h7);
        idle(20);
        rd(5'h0C, 32'h0, "R5 not yet set");
        rd(5'h0C, 32'h1, "R5 set at count 20");
        rd_irq(1'b1, "R8 irq with flag and enable");
        // R7: clear collides with a live event
        wr(5'h0C, 32'h1);
        rd(5'h0C, 32'h1, "R7 event wins over clear");
        wr(5'h08, 32'h5);
        wr(5'h0C, 32'h1);
        rd(5'h0C, 32'h0, "R7 clear with no event");
        rd_irq(1'b0, "R8 irq drops with flag");
        // R5: counter already past compare (not equality)
        wr(5'h08, 32'h7);
        rd(5'h0C, 32'h0, "R5 one cycle after enable");
        rd(5'h0C, 32'h1, "R5 greater-than fires");
        wr(5'h08, 32'h3);
        rd_irq(1'b0, "R8 irq masked by enable");
        rd(5'h0C, 32'h1, "R8 flag kept while masked");

        // R9: periodic reload
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'd5);
        wr(5'h18, 32'd8);
        wr(5'h08, 32'hF);
        idle(6);
        rd(5'h10, 32'd13, "R9 first reload");
        rd(5'h0C, 32'h1, "R9 flag on first event");
        wr(5'h0C, 32'h1);
        rd(5'h0C, 32'h0, "R9 flag cleared between events");
        idle(3);
        rd(5'h10, 32'd13, "R9 no add without event");
        rd(5'h10, 32'd21, "R9 second reload");
        rd(5'h0C, 32'h1, "R9 flag on second event");
        rd(5'h18, 32'd8, "R9 step readback");
        rd(5'h14, 32'h0, "R9 compare high word");
        rd(5'h08, 32'hF, "R10 control readback");

        // R1: unmapped write ignored
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, 32'h0, "R1 unmapped read");
        rd(5'h08, 32'hF, "R1 control untouched by unmapped write");
        rd(5'h18, 32'd8, "R1 step untouched by unmapped write");

        idle(3);
        done = 1'b1;
        report();
    end
endmodule